// File: doc/BRIEF.md
# Compare-Event Trigger Divider with Phase Offset

This block turns PWM compare events into single-cycle trigger strobes for an ADC and for a timebase capture. Three compare-event strobes (A, B, C) each pass through their own enable bit. The enabled strobes are merged into one stream of qualifying events. Strobes from several enabled sources in the same clock cycle count as a single event.

Each of two identical divider paths counts the qualifying events. The first path produces the ADC trigger and the second produces the capture trigger. A path first skips a programmable number of events, which shifts the phase of its output. It then emits one strobe for every N+1 events. Each path has its own 5-bit divide field and its own 5-bit skip field.

Configuration is written while the generator is off. Switching the generator on starts both paths from their programmed values. Switching it off clears the paths and silences both outputs.

Top module: `trig_postscale_offset`

## Requirements
- R1: After reset, both trigger outputs are low.
- R2: A compare strobe whose enable bit is 0 never counts as an event. Enable bit 0 gates source A, bit 1 gates source B and bit 2 gates source C.
- R3: Strobes from several enabled sources in the same cycle count as exactly one event.
- R4: With divide field 0 and skip field 0, the trigger pulses high for one cycle in the clock cycle after each qualifying event.
- R5: A divide field of N (0 to 31) yields one trigger per N+1 events once the skip phase has ended.
- R6: A skip field of K (0 to 31) makes the first trigger appear on qualifying event K+N+1 after turn-on. Later triggers follow every N+1 events.
- R7: While the generator is off, both outputs stay low and no event is counted. Each turn-on restarts the counting from the programmed values.
- R8: The capture trigger path uses its own divide and skip fields and counts the same event stream independently of the ADC path.
- R9: With both fields at their maximum of 31, the first trigger falls on event 63 and later triggers follow every 32 events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_on | input | 1 | Generator on; counting runs only while high |
| cmp_evt | input | 3 | Single-cycle compare strobes: bit 0 is A, bit 1 is B, bit 2 is C |
| adc_src_en | input | 3 | Per-source enable: bit 0 is A, bit 1 is B, bit 2 is C |
| adc_div | input | 5 | ADC path divide field N (ratio 1:N+1) |
| adc_skip | input | 5 | ADC path skip field K (events skipped before division starts) |
| cap_div | input | 5 | Capture path divide field |
| cap_skip | input | 5 | Capture path skip field |
| adc_trig | output | 1 | ADC trigger strobe |
| cap_trig | output | 1 | Timebase-capture trigger strobe |

## Verification
The case that is hardest to reach is the far end of the count range. With divide and skip both at 31, the first trigger needs 63 qualifying events, so events are spread out and it rarely shows up. The stimulus reaches it by holding the enabled strobes high for hundreds of consecutive cycles. An off/on toggle is placed in the middle of a partly completed skip phase, to show that the restart discards the partial count. A reference model in the bench counts events since turn-on and predicts both outputs on every clock.

// File: rtl/trig_ps_pkg.sv
package trig_ps_pkg;
    localparam int unsigned NUM_SRC = 3;
    localparam int unsigned CFG_W   = 5;

    typedef enum logic [1:0] {
        SRC_A = 2'd0,
        SRC_B = 2'd1,
        SRC_C = 2'd2
    } src_idx_e;
endpackage

// File: rtl/evt_merge.sv
module evt_merge #(
    parameter int unsigned NSRC = trig_ps_pkg::NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] strobe_i,
    input  logic [NSRC-1:0] enable_i,
    output logic            qual_o
);
    logic [NSRC-1:0] gated;

    // Each source is gated by its own enable.
    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign gated[g] = strobe_i[g] & enable_i[g];
    end

    // Simultaneous strobes collapse into one event.
    always_comb begin
        qual_o = |gated;
    end

    // R2: a disabled source never raises the merged event stream.
    p_gate_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((strobe_i & enable_i) == '0) |-> !qual_o);
endmodule

// File: rtl/scale_offset.sv
module scale_offset #(
    parameter int unsigned CW = trig_ps_pkg::CFG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          on_i,
    input  logic          evt_i,
    input  logic [CW-1:0] div_i,
    input  logic [CW-1:0] skip_i,
    output logic          pulse_o
);
    localparam logic [CW-1:0] ZERO = '0;

    typedef struct packed {
        logic [CW-1:0] skip;
        logic [CW-1:0] div;
        logic          run;
        logic          pulse;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] skip_eff, div_eff;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        // On the first cycle after turn-on, use the field values directly.
        skip_eff   = st_q.run ? st_q.skip : skip_i;
        div_eff    = st_q.run ? st_q.div  : div_i;
        if (!on_i) begin
            st_d = '0;
        end else begin
            st_d.run  = 1'b1;
            st_d.skip = skip_eff;
            st_d.div  = div_eff;
            if (evt_i) begin
                if (skip_eff != ZERO) begin
                    st_d.skip = skip_eff - 1'b1;
                end else if (div_eff == ZERO) begin
                    st_d.pulse = 1'b1;
                    st_d.div   = div_i;
                end else begin
                    st_d.div = div_eff - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R7: off means silent and cleared on the next cycle.
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !on_i |=> (!pulse_o && !st_q.run && st_q.skip == ZERO && st_q.div == ZERO));
    // R5: no pulse without a qualifying event in the cycle before.
    p_pulse_needs_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> !pulse_o);
    // R4: unity ratio with no skip passes every event.
    p_unity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (on_i && evt_i && div_i == ZERO && skip_i == ZERO) |=> pulse_o);
    // R6: the skip count never rises above its field while running.
    p_skip_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && on_i) |-> (st_q.skip <= skip_i));
    // R5: the divide count never rises above its field while running.
    p_div_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && on_i) |-> (st_q.div <= div_i));
endmodule

// File: rtl/trig_postscale_offset.sv
module trig_postscale_offset
    import trig_ps_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC,
    parameter int unsigned CW   = CFG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gen_on,
    input  logic [NSRC-1:0] cmp_evt,
    input  logic [NSRC-1:0] adc_src_en,
    input  logic [CW-1:0]   adc_div,
    input  logic [CW-1:0]   adc_skip,
    input  logic [CW-1:0]   cap_div,
    input  logic [CW-1:0]   cap_skip,
    output logic            adc_trig,
    output logic            cap_trig
);
    localparam int unsigned NPATH = 2;

    logic             qual;
    logic [CW-1:0]    div_sel  [NPATH];
    logic [CW-1:0]    skip_sel [NPATH];
    logic [NPATH-1:0] trig;

    evt_merge #(.NSRC(NSRC)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (cmp_evt),
        .enable_i (adc_src_en),
        .qual_o   (qual)
    );

    always_comb begin
        div_sel[0]  = adc_div;
        skip_sel[0] = adc_skip;
        div_sel[1]  = cap_div;
        skip_sel[1] = cap_skip;
    end

    // Path 0 drives the ADC trigger and path 1 the capture trigger.
    for (genvar p = 0; p < NPATH; p++) begin : g_path
        scale_offset #(.CW(CW)) u_so (
            .clk     (clk),
            .rst_n   (rst_n),
            .on_i    (gen_on),
            .evt_i   (qual),
            .div_i   (div_sel[p]),
            .skip_i  (skip_sel[p]),
            .pulse_o (trig[p])
        );
    end

    assign adc_trig = trig[0];
    assign cap_trig = trig[1];

    // R3 and R2: with no enabled strobe, neither trigger fires on the next cycle.
    p_no_src_no_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_evt & adc_src_en) == '0) |=> (!adc_trig && !cap_trig));
endmodule

// File: tb/sim_trig_postscale_offset.sv
`timescale 1ns/1ps
module sim_trig_postscale_offset;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_on = 1'b0;
    logic [2:0] cmp_evt = '0;
    logic [2:0] adc_src_en = '0;
    logic [4:0] adc_div = '0, adc_skip = '0, cap_div = '0, cap_skip = '0;
    logic       adc_trig, cap_trig;

    int errors = 0, checks = 0, cyc = 0;
    int cnt = 0;
    int n_adc = 0, n_cap = 0;
    bit exp_a = 0, exp_c = 0, finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    trig_postscale_offset u0 (
        .clk(clk), .rst_n(rst_n), .gen_on(gen_on), .cmp_evt(cmp_evt),
        .adc_src_en(adc_src_en), .adc_div(adc_div), .adc_skip(adc_skip),
        .cap_div(cap_div), .cap_skip(cap_skip),
        .adc_trig(adc_trig), .cap_trig(cap_trig)
    );

    function automatic bit model_hit(int n, int k, int d);
        return (n > k) && (((n - k) % (d + 1)) == 0);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic step(logic [2:0] s);
        cmp_evt = s;
        if (!gen_on) begin
            cnt = 0; exp_a = 0; exp_c = 0;
        end else if ((s & adc_src_en) != 0) begin
            cnt++;
            exp_a = model_hit(cnt, adc_skip, adc_div);
            exp_c = model_hit(cnt, cap_skip, cap_div);
        end else begin
            exp_a = 0; exp_c = 0;
        end
        @(posedge clk); #1;
        check({cur_req, " adc"}, adc_trig, exp_a);
        check({cur_req, " cap"}, cap_trig, exp_c);
        n_adc += adc_trig;
        n_cap += cap_trig;
    endtask

    task automatic setup(logic [2:0] en, int ad, int ak, int cd, int ck);
        gen_on = 1'b0;
        step(3'b000);
        adc_src_en = en;
        adc_div = ad[4:0]; adc_skip = ak[4:0];
        cap_div = cd[4:0]; cap_skip = ck[4:0];
        gen_on = 1'b1;
        n_adc = 0; n_cap = 0;
    endtask

    task automatic run_rand(int n, int density);
        for (int i = 0; i < n; i++) begin
            logic [2:0] s;
            s = '0;
            for (int b = 0; b < 3; b++) s[b] = (($urandom % 100) < density);
            step(s);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        cur_req = "R1";
        check("R1 adc", adc_trig, 0);
        check("R1 cap", cap_trig, 0);
        rst_n = 1'b1;
        step(3'b000);

        // R4: unity ratio, no skip
        cur_req = "R4";
        setup(3'b111, 0, 0, 0, 0);
        run_rand(60, 30);
        for (int i = 0; i < 5; i++) step(3'b001);

        // R2: only source B enabled, then A and C strobes alone
        cur_req = "R2";
        setup(3'b010, 0, 0, 0, 0);
        run_rand(40, 40);
        n_adc = 0;
        for (int i = 0; i < 20; i++) step(3'b101);
        check("R2 gated count", n_adc, 0);

        // R3: all three strobes together count once
        cur_req = "R3";
        setup(3'b111, 1, 0, 1, 0);
        for (int i = 0; i < 10; i++) step(3'b111);
        check("R3 pulse count", n_adc, 5);

        // R5: divide ratios
        cur_req = "R5";
        setup(3'b111, 3, 0, 3, 0);
        run_rand(80, 50);
        setup(3'b011, 31, 0, 31, 0);
        for (int i = 0; i < 96; i++) step(3'b010);
        check("R5 1:32 count", n_adc, 3);

        // R6: skip then divide
        cur_req = "R6";
        setup(3'b100, 2, 5, 2, 5);
        for (int i = 0; i < 14; i++) step(3'b100);
        check("R6 first pulses", n_adc, 3);
        run_rand(60, 40);

        // R8: independent capture path
        cur_req = "R8";
        setup(3'b111, 1, 3, 4, 7);
        run_rand(120, 35);
        setup(3'b001, 0, 0, 6, 2);
        for (int i = 0; i < 30; i++) step(3'b001);
        check("R8 adc count", n_adc, 30);
        check("R8 cap count", n_cap, 4);

        // R7: turn off mid skip phase, strobes while off, restart
        cur_req = "R7";
        setup(3'b111, 1, 4, 0, 3);
        for (int i = 0; i < 3; i++) step(3'b001);
        gen_on = 1'b0;
        n_adc = 0; n_cap = 0;
        for (int i = 0; i < 10; i++) step(3'b111);
        check("R7 off adc count", n_adc, 0);
        check("R7 off cap count", n_cap, 0);
        gen_on = 1'b1;
        for (int i = 0; i < 4; i++) step(3'b010);
        check("R7 restart cap", n_cap, 1);
        check("R7 restart adc", n_adc, 0);
        run_rand(40, 40);

        // R9: maximum fields
        cur_req = "R9";
        setup(3'b111, 31, 31, 31, 31);
        for (int i = 0; i < 200; i++) step(3'b001);
        check("R9 pulse count", n_adc, 5);
        gen_on = 1'b0;
        step(3'b000);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule